// File: doc/BRIEF.md
# Split Enable/Clear Interrupt Aggregator

This block gathers single-cycle event pulses from five interrupt sources into sticky pending latches and presents them to a CPU as one level-sensitive request. The sources are an external pin, timer 1, timer 2, an asynchronous serial port and a synchronous serial port. An event is latched only when software has enabled that source and an upstream global enable input is high.

Software sees one 16-bit register. A write puts the source enables into the low byte and write-one-to-clear bits into the high byte, so one store can re-arm sources and acknowledge interrupts together. A read of the same register returns the pending latches and never the enables. Byte lanes are honoured, so a byte store touches only its own half. The high byte, which holds the clear bits, is the even byte on a big-endian bus.

Top module: `irq_agg_top`

## Requirements
- R1: While `rst` is high on a clock edge, all enables and pending latches clear, and `irq_req` is 0 one edge later.
- R2: Bit i of `src_evt` (0 external, 1 timer 1, 2 timer 2, 3 asynchronous serial, 4 synchronous serial) sets pending bit i at the edge where it is sampled, if enable i is 1 and `global_en` is 1.
- R3: An event on a source whose enable bit is 0 leaves its pending bit unchanged.
- R4: With `global_en` low, no event sets any pending bit.
- R5: A write with `wr_be[0]` high loads enables from `wr_data[4:0]` (same bit order as R2). The new enables apply to events sampled at later edges; an event in the same cycle as the write uses the previous enables.
- R6: A write with `wr_be[1]` high clears pending bit i when `wr_data[8+i]` is 1 and leaves it unchanged when that bit is 0.
- R7: `rd_data[4:0]` carries the pending bits in R2 order and `rd_data[15:5]` is 0. It never shows the enables.
- R8: `irq_req` is registered. It is 1 one edge after any pending bit is 1 and stays 1 until one edge after every pending bit has been cleared.
- R9: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: Byte lanes are independent. With `wr_be[1]` low the clear bits have no effect, and with `wr_be[0]` low the enables keep their value.
- R11: A pending bit stays set after its event ends, until it is cleared or the block is reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| global_en | input | 1 | Upstream gate for all event latching |
| src_evt | input | 5 | Per-source event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte lanes: bit 1 for data 15:8 (clears), bit 0 for data 7:0 (enables) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Pending latches, zero-extended |
| irq_req | output | 1 | Level interrupt request to the CPU |

## Verification
Each stimulus is applied between edges and takes effect at the next rising edge. The pending bits, and so `rd_data`, change at that edge. `irq_req` reflects the pending state one edge later, because it has its own output register. For every driven cycle the driver computes both results from a model of the requirements and queues them. Shortly after each rising edge the monitor takes the oldest queued item and compares it, so every result is checked at the exact edge it is due. The stimulus includes a write and an event in the same cycle, a set and a clear in the same cycle, and writes on one byte lane only, so that the old-enable and set-wins rules are checked at their edges.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // number of interrupt sources and register geometry
  localparam int unsigned SRC_N    = 5;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned CLR_BASE = 8;
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode #(
  parameter int unsigned N_SRC    = irq_agg_pkg::SRC_N,
  parameter int unsigned DATA_W   = irq_agg_pkg::REG_W,
  parameter int unsigned CLR_OFS  = irq_agg_pkg::CLR_BASE,
  localparam int unsigned LANES   = DATA_W / 8,
  localparam int unsigned CLR_LN  = CLR_OFS / 8
) (
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic              en_load,
  output logic [N_SRC-1:0]  en_val,
  output logic [N_SRC-1:0]  clr_vec
);
  logic unused_data;

  // low lane carries enables, lane holding CLR_OFS carries clears
  assign en_load = wr_en & wr_be[0];
  assign en_val  = wr_data[N_SRC-1:0];

  always_comb begin
    clr_vec = '0;
    if (wr_en && wr_be[CLR_LN])
      clr_vec = wr_data[CLR_OFS +: N_SRC];
  end

  assign unused_data = ^wr_data;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned N_SRC = irq_agg_pkg::SRC_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_load,
  input  logic [N_SRC-1:0] en_val,
  output logic [N_SRC-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)          en_q <= '0;
    else if (en_load) en_q <= en_val;
  end

  // R5
  en_load_chk: assert property (@(posedge clk) disable iff (rst)
    en_load |=> (en_q == $past(en_val)));

  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en_load |=> $stable(en_q));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N_SRC = irq_agg_pkg::SRC_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             global_en,
  input  logic [N_SRC-1:0] src_evt,
  input  logic [N_SRC-1:0] en_q,
  input  logic [N_SRC-1:0] clr_vec,
  output logic [N_SRC-1:0] pend_q
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic set_i;
    assign set_i = src_evt[i] & en_q[i] & global_en;

    // set has priority over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst)             pend_q[i] <= 1'b0;
      else if (set_i)      pend_q[i] <= 1'b1;
      else if (clr_vec[i]) pend_q[i] <= 1'b0;
    end

    // R2 R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (src_evt[i] && en_q[i] && global_en) |=> pend_q[i]);

    // R3 R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
      (!pend_q[i] && !(src_evt[i] && en_q[i] && global_en)) |=> !pend_q[i]);

    // R6
    clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[i] && !(src_evt[i] && en_q[i] && global_en)) |=> !pend_q[i]);

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !clr_vec[i]) |=> pend_q[i]);
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (pend_q == '0));
endmodule

// File: rtl/irq_req_drv.sv
module irq_req_drv #(
  parameter int unsigned N_SRC = irq_agg_pkg::SRC_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend_q,
  output logic             irq_req
);
  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= |pend_q;
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top #(
  parameter int unsigned N_SRC   = irq_agg_pkg::SRC_N,
  parameter int unsigned DATA_W  = irq_agg_pkg::REG_W,
  parameter int unsigned CLR_OFS = irq_agg_pkg::CLR_BASE,
  localparam int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              global_en,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_req
);
  logic             en_load;
  logic [N_SRC-1:0] en_val;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] pend_q;

  irq_wr_decode #(.N_SRC(N_SRC), .DATA_W(DATA_W), .CLR_OFS(CLR_OFS)) i_dec (
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .en_load(en_load), .en_val(en_val), .clr_vec(clr_vec)
  );

  irq_enable_reg #(.N_SRC(N_SRC)) i_en (
    .clk(clk), .rst(rst), .en_load(en_load), .en_val(en_val), .en_q(en_q)
  );

  irq_pend_bank #(.N_SRC(N_SRC)) i_pend (
    .clk(clk), .rst(rst), .global_en(global_en), .src_evt(src_evt),
    .en_q(en_q), .clr_vec(clr_vec), .pend_q(pend_q)
  );

  irq_req_drv #(.N_SRC(N_SRC)) i_req (
    .clk(clk), .rst(rst), .pend_q(pend_q), .irq_req(irq_req)
  );

  // read view is the pending state only
  assign rd_data = {{(DATA_W-N_SRC){1'b0}}, pend_q};

  // R8
  req_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|pend_q) |=> irq_req);

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0) |=> !irq_req);

  // R7
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:N_SRC] == '0);
endmodule

// File: tb/test_irq_agg_top.sv
module test_irq_agg_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        global_en;
  logic [4:0]  src_evt;
  logic        wr_en;
  logic [1:0]  wr_be;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        irq_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] q_rd[$];
  logic        q_irq[$];
  string       q_tag[$];

  logic [4:0] m_en, m_pend;

  always #5 clk = ~clk;

  irq_agg_top i_irq_agg_top (
    .clk(clk), .rst(rst), .global_en(global_en), .src_evt(src_evt),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .irq_req(irq_req)
  );

  // driver: applies one cycle of stimulus and queues what the next edge must yield
  task automatic step(input logic r, input logic g, input logic [4:0] ev,
                      input logic we, input logic [1:0] be, input logic [15:0] d,
                      input string tag);
    logic [4:0] clr, setv;
    logic       nirq;
    @(negedge clk);
    rst = r; global_en = g; src_evt = ev; wr_en = we; wr_be = be; wr_data = d;
    if (r) begin
      m_pend = '0; m_en = '0; nirq = 1'b0;
    end else begin
      clr  = (we && be[1]) ? d[12:8] : 5'b0;
      setv = ev & m_en & {5{g}};
      nirq = |m_pend;
      m_pend = (m_pend & ~clr) | setv;
      if (we && be[0]) m_en = d[4:0];
    end
    q_rd.push_back({11'b0, m_pend});
    q_irq.push_back(nirq);
    q_tag.push_back(tag);
  endtask

  // monitor: compares after each rising edge
  always @(posedge clk) begin
    #2;
    if (q_rd.size() > 0) begin
      logic [15:0] er; logic ei; string t;
      er = q_rd.pop_front(); ei = q_irq.pop_front(); t = q_tag.pop_front();
      n_cmp++;
      if (rd_data !== er) begin
        n_bad++;
        $display("FAIL %s rd_data: actual %h expected %h", t, rd_data, er);
      end
      n_cmp++;
      if (irq_req !== ei) begin
        n_bad++;
        $display("FAIL %s irq_req: actual %b expected %b", t, irq_req, ei);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_en = '0; m_pend = '0;
    rst = 1'b1; global_en = 1'b0; src_evt = '0; wr_en = 1'b0; wr_be = '0; wr_data = '0;
    // R1 reset state
    step(1, 0, 5'h00, 0, 2'b00, 16'h0000, "R1");
    step(1, 1, 5'h1F, 1, 2'b11, 16'h001F, "R1");
    step(1, 0, 5'h00, 0, 2'b00, 16'h0000, "R1");
    // R3 events with all enables off
    step(0, 1, 5'h1F, 0, 2'b00, 16'h0000, "R3");
    step(0, 1, 5'h00, 0, 2'b00, 16'h0000, "R3");
    // R5 enable write, event same cycle uses old enables
    step(0, 1, 5'h01, 1, 2'b01, 16'h001F, "R5");
    // R4 global gate low
    step(0, 0, 5'h1F, 0, 2'b00, 16'h0000, "R4");
    step(0, 0, 5'h00, 0, 2'b00, 16'h0000, "R4");
    // R2 external source latches
    step(0, 1, 5'h01, 0, 2'b00, 16'h0000, "R2");
    // R7 R8 read shows pending, not enables; request follows
    step(0, 1, 5'h00, 0, 2'b00, 16'h0000, "R7_R8");
    // R2 timer 1 and async serial
    step(0, 1, 5'h0A, 0, 2'b00, 16'h0000, "R2");
    // R11 sticky
    step(0, 1, 5'h00, 0, 2'b00, 16'h0000, "R11");
    step(0, 0, 5'h00, 0, 2'b00, 16'h0000, "R11");
    // R6 clear timer 1 only, zero bits keep others
    step(0, 1, 5'h00, 1, 2'b10, 16'h02E0, "R6");
    // R10 low lane only: clear bits ignored, enables become zero
    step(0, 1, 5'h00, 1, 2'b01, 16'h1F00, "R10");
    step(0, 1, 5'h04, 0, 2'b00, 16'h0000, "R10_R3");
    // R10 high lane only: enable bits ignored
    step(0, 1, 5'h00, 1, 2'b10, 16'h001F, "R10");
    step(0, 1, 5'h10, 0, 2'b00, 16'h0000, "R10_R3");
    // re-enable selected sources
    step(0, 1, 5'h00, 1, 2'b01, 16'h0014, "R5");
    step(0, 1, 5'h03, 0, 2'b00, 16'h0000, "R3");
    // R9 set and clear same bit same cycle
    step(0, 1, 5'h10, 1, 2'b10, 16'h1000, "R9");
    step(0, 1, 5'h00, 0, 2'b00, 16'h0000, "R9");
    // R8 clear everything, request drops one edge later
    step(0, 1, 5'h00, 1, 2'b10, 16'h1F00, "R8");
    step(0, 1, 5'h00, 0, 2'b00, 16'h0000, "R8");
    // both lanes: new enables and clear together
    step(0, 1, 5'h04, 1, 2'b11, 16'h0408, "R6_R5");
    step(0, 1, 5'h08, 0, 2'b00, 16'h0000, "R2");
    step(0, 1, 5'h1F, 1, 2'b00, 16'h1F1F, "R10");
    step(0, 1, 5'h00, 1, 2'b11, 16'h1F00, "R6");
    step(0, 1, 5'h00, 0, 2'b00, 16'h0000, "R8");
    // R1 reset mid-run
    step(0, 1, 5'h00, 1, 2'b01, 16'h001F, "R5");
    step(0, 1, 5'h1F, 0, 2'b00, 16'h0000, "R2");
    step(1, 1, 5'h00, 0, 2'b00, 16'h0000, "R1");
    step(0, 1, 5'h1F, 0, 2'b00, 16'h0000, "R1_R3");
    step(0, 1, 5'h00, 0, 2'b00, 16'h0000, "R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule